// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block keeps the CPU-visible status of three CAN transmit message buffers. Each buffer has an empty flag, an interrupt enable, an abort request and an abort acknowledge. A transmit engine reports two kinds of event for each buffer: a message was sent, and an abort finished. From this state the block drives one transmit interrupt request and a per-buffer lock that stops the CPU from touching a buffer while it waits to be sent.

The CPU sees four 8-bit registers, selected by a 2-bit address. Address 0 holds the empty flags. Address 1 holds the interrupt enables. Address 2 holds the abort requests. Address 3 holds the abort acknowledges and is read-only. Only the low bits are implemented, and the upper bits read as zero. A read returns its data on the clock edge after `cpu_rd`. While initialization mode is active, the buffer status is frozen at its reset value. While listen mode is active, the CPU cannot hand a buffer over for transmission.

Top module: `can_txbuf_status`

## Requirements
- R1: After a synchronous reset, every empty flag is 1. The interrupt enables, abort requests and abort acknowledges are 0. `irq` and `buf_lock` are 0.
- R2: A write to address 0 clears each empty flag whose data bit is 1. Zero bits leave their flag unchanged. Bits 7:3 of every register read as 0.
- R3: A `sent_ok` pulse for a buffer sets its empty flag.
- R4: An `abort_done` pulse sets the buffer's empty flag and its abort acknowledge, but only while that buffer's abort request is 1. Without a pending request the pulse is ignored.
- R5: A write of 1 to a bit at address 2 sets that abort request, but only while the buffer's empty flag is 0. A write of 0 is ignored. The request is cleared whenever the empty flag becomes set.
- R6: A CPU clear of an empty flag also clears that buffer's abort acknowledge.
- R7: Initialization mode is active only when `init_req` and `init_ack` are both 1. While it is active, the flags, requests and acknowledges are held at their reset values and CPU writes to them have no effect. Either input alone has no such effect.
- R8: While `listen` is 1, CPU writes cannot clear empty flags. Engine events still set them.
- R9: `irq` is 1 exactly when some buffer has both its empty flag and its interrupt enable at 1.
- R10: Bit i of `buf_lock` is 1 exactly when empty flag i is 0.
- R11: When an engine event and a CPU clear hit the same flag in the same cycle, the flag ends at 1.
- R12: The interrupt enables at address 1 can be written and read in every mode, including initialization mode. Read data appears one cycle after `cpu_rd`. `irq` and `buf_lock` reflect a write or event on the edge that applies it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode request |
| init_ack | input | 1 | Initialization mode acknowledge |
| listen | input | 1 | Listen-only mode |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select: 0 flags, 1 enables, 2 abort requests, 3 abort acknowledges |
| cpu_wdata | input | NBUF | Write data, one bit per buffer |
| cpu_rdata | output | DW | Registered read data |
| sent_ok | input | NBUF | Per-buffer pulse: message sent |
| abort_done | input | NBUF | Per-buffer pulse: abort completed |
| irq | output | 1 | Transmit interrupt request |
| buf_lock | output | NBUF | Per-buffer CPU access block |

## Verification
The bench targets four corner cases:
- **Abort pulse without a request.** The bench fires an abort pulse at a buffer that has no pending request. A design that skipped the gate would free the buffer and raise a false acknowledge.
- **Same-cycle collision.** The bench lands a CPU clear and a sent event on the same flag in one cycle. A design that let the clear win would lose a completion and lock the buffer for good.
- **One-sided initialization.** The bench raises `init_req` without `init_ack`. A design that decoded only one signal would freeze the flags at the wrong time.
- **Listen mode and the flag-clear coupling.** The bench checks that clears are blocked in listen mode while events still set flags. It also checks that setting a flag drops the request, that clearing a flag drops the acknowledge, and that an abort request on an empty buffer is refused.

// File: rtl/can_txbuf_pkg.sv
package can_txbuf_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EMPTY = 2'd0,
    SEL_IEN   = 2'd1,
    SEL_ABREQ = 2'd2,
    SEL_ABACK = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/txbuf_slot.sv
// Status of one transmit buffer: empty flag, abort request, abort acknowledge.
module txbuf_slot (
  input  logic clk,
  input  logic rst,
  input  logic init_i,
  input  logic listen_i,
  input  logic clr_wr_i,
  input  logic abrq_wr_i,
  input  logic sent_i,
  input  logic abort_i,
  output logic flag_d_o,
  output logic flag_o,
  output logic req_o,
  output logic ack_o
);
  logic flag_q, req_q, ack_q;
  logic flag_d, req_d, ack_d;
  logic aborted, set_ev;

  always_comb begin
    aborted = abort_i & req_q;
    set_ev  = sent_i | aborted;
    flag_d  = flag_q;
    req_d   = req_q;
    ack_d   = ack_q;
    if (init_i) begin
      flag_d = 1'b1;
      req_d  = 1'b0;
      ack_d  = 1'b0;
    end else if (set_ev) begin
      flag_d = 1'b1;
      req_d  = 1'b0;
      if (aborted) ack_d = 1'b1;
    end else if (clr_wr_i && !listen_i) begin
      flag_d = 1'b0;
      ack_d  = 1'b0;
    end else if (abrq_wr_i && !flag_q) begin
      req_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b1;
      req_q  <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      req_q  <= req_d;
      ack_q  <= ack_d;
    end
  end

  assign flag_d_o = flag_d;
  assign flag_o   = flag_q;
  assign req_o    = req_q;
  assign ack_o    = ack_q;

  assert_init_hold_R7: assert property (@(posedge clk) disable iff (rst)
    init_i |=> (flag_q && !req_q && !ack_q));
  assert_set_drops_req_R5: assert property (@(posedge clk) disable iff (rst)
    !flag_q |=> (!flag_q || !req_q));
  assert_clear_drops_ack_R6: assert property (@(posedge clk) disable iff (rst)
    flag_q |=> (flag_q || !ack_q));
  assert_listen_keeps_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (listen_i && !init_i && flag_q) |=> flag_q);
endmodule

// File: rtl/txbuf_regif.sv
// Registered read multiplexer for the four status registers.
module txbuf_regif
  import can_txbuf_pkg::*;
#(
  parameter int NBUF = 3,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NBUF-1:0]   flag_i,
  input  logic [NBUF-1:0]   ien_i,
  input  logic [NBUF-1:0]   req_i,
  input  logic [NBUF-1:0]   ack_i,
  output logic [DW-1:0]     rdata_o
);
  localparam int PAD = DW - NBUF;
  logic [NBUF-1:0] sel_bits;

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_EMPTY: sel_bits = flag_i;
      SEL_IEN:   sel_bits = ien_i;
      SEL_ABREQ: sel_bits = req_i;
      default:   sel_bits = ack_i;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (rd_i) rdata_o <= {{PAD{1'b0}}, sel_bits};
  end
endmodule

// File: rtl/can_txbuf_status.sv
module can_txbuf_status
  import can_txbuf_pkg::*;
#(
  parameter int NBUF = 3,
  parameter int DW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_req,
  input  logic              init_ack,
  input  logic              listen,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [NBUF-1:0]   cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  input  logic [NBUF-1:0]   sent_ok,
  input  logic [NBUF-1:0]   abort_done,
  output logic              irq,
  output logic [NBUF-1:0]   buf_lock
);
  logic            init_mode;
  logic            wr_flag, wr_ien, wr_abrq;
  logic [NBUF-1:0] flag_d, flag_q, req_q, ack_q;
  logic [NBUF-1:0] ien_q, ien_d;

  assign init_mode = init_req & init_ack;
  assign wr_flag   = cpu_wr && (reg_sel_e'(cpu_addr) == SEL_EMPTY) && !init_mode;
  assign wr_abrq   = cpu_wr && (reg_sel_e'(cpu_addr) == SEL_ABREQ) && !init_mode;
  assign wr_ien    = cpu_wr && (reg_sel_e'(cpu_addr) == SEL_IEN);
  assign ien_d     = wr_ien ? cpu_wdata : ien_q;

  for (genvar b = 0; b < NBUF; b++) begin : g_slot
    txbuf_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .init_i   (init_mode),
      .listen_i (listen),
      .clr_wr_i (wr_flag & cpu_wdata[b]),
      .abrq_wr_i(wr_abrq & cpu_wdata[b]),
      .sent_i   (sent_ok[b]),
      .abort_i  (abort_done[b]),
      .flag_d_o (flag_d[b]),
      .flag_o   (flag_q[b]),
      .req_o    (req_q[b]),
      .ack_o    (ack_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q    <= '0;
      irq      <= 1'b0;
      buf_lock <= '0;
    end else begin
      ien_q    <= ien_d;
      irq      <= |(flag_d & ien_d);
      buf_lock <= ~flag_d;
    end
  end

  txbuf_regif #(.NBUF(NBUF), .DW(DW)) u_regif (
    .clk    (clk),
    .rst    (rst),
    .rd_i   (cpu_rd),
    .addr_i (cpu_addr),
    .flag_i (flag_q),
    .ien_i  (ien_q),
    .req_i  (req_q),
    .ack_i  (ack_q),
    .rdata_o(cpu_rdata)
  );

  assert_irq_matches_R9: assert property (@(posedge clk) disable iff (rst)
    irq == |(flag_q & ien_q));
  assert_lock_matches_R10: assert property (@(posedge clk) disable iff (rst)
    buf_lock == ~flag_q);
endmodule

// File: tb/test_can_txbuf_status.sv
module test_can_txbuf_status;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       init_req = 1'b0, init_ack = 1'b0, listen = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [1:0] cpu_addr = '0;
  logic [2:0] cpu_wdata = '0, sent_ok = '0, abort_done = '0;
  logic [7:0] cpu_rdata;
  logic       irq;
  logic [2:0] buf_lock;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  can_txbuf_status i_can_txbuf_status (
    .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
    .listen(listen), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sent_ok(sent_ok),
    .abort_done(abort_done), .irq(irq), .buf_lock(buf_lock)
  );

  typedef struct packed {
    logic       wr;
    logic [1:0] addr;
    logic [2:0] wdata;
    logic [2:0] sent;
    logic [2:0] abt;
    logic       lsn;
    logic       init;
    logic [2:0] eflag;
    logic       eirq;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd1, 3'b101, 3'b000, 3'b000, 1'b0, 1'b0, 3'b111, 1'b1, 4'd9},  // R9 R12 enables
    '{1'b1, 2'd0, 3'b111, 3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 4'd2},  // R2 clear all
    '{1'b1, 2'd2, 3'b010, 3'b000, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 4'd5},  // R5 request abort 1
    '{1'b0, 2'd0, 3'b000, 3'b000, 3'b010, 1'b0, 1'b0, 3'b010, 1'b0, 4'd4},  // R4 abort done 1
    '{1'b0, 2'd0, 3'b000, 3'b001, 3'b000, 1'b0, 1'b0, 3'b011, 1'b1, 4'd3},  // R3 sent 0
    '{1'b1, 2'd0, 3'b010, 3'b000, 3'b000, 1'b0, 1'b0, 3'b001, 1'b1, 4'd6},  // R6 clear 1
    '{1'b1, 2'd0, 3'b001, 3'b000, 3'b000, 1'b1, 1'b0, 3'b001, 1'b1, 4'd8},  // R8 blocked clear
    '{1'b0, 2'd0, 3'b000, 3'b100, 3'b000, 1'b1, 1'b0, 3'b101, 1'b1, 4'd8},  // R8 event in listen
    '{1'b1, 2'd0, 3'b000, 3'b000, 3'b000, 1'b0, 1'b0, 3'b101, 1'b1, 4'd2},  // R2 zeros ignored
    '{1'b1, 2'd0, 3'b100, 3'b000, 3'b000, 1'b0, 1'b0, 3'b001, 1'b1, 4'd2},  // R2 clear 2
    '{1'b0, 2'd0, 3'b000, 3'b000, 3'b010, 1'b0, 1'b0, 3'b001, 1'b1, 4'd4},  // R4 no pending req
    '{1'b0, 2'd0, 3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 3'b111, 1'b1, 4'd7},  // R7 init forces
    '{1'b1, 2'd0, 3'b111, 3'b000, 3'b000, 1'b0, 1'b1, 3'b111, 1'b1, 4'd7},  // R7 write ignored
    '{1'b1, 2'd1, 3'b000, 3'b000, 3'b000, 1'b0, 1'b1, 3'b111, 1'b0, 4'd12}  // R12 enable in init
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr = 1'b0; cpu_rd = 1'b0; sent_ok = '0; abort_done = '0; cpu_wdata = '0;
  endtask

  task automatic write(input logic [1:0] a, input logic [2:0] d);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic read_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
    cpu_rd = 1'b1; cpu_addr = a;
    @(negedge clk);
    idle();
    check(tag, cpu_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 lock", {5'b0, buf_lock}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    read_chk(2'd0, 8'h07, "R1 flags");
    read_chk(2'd1, 8'h00, "R1 enables");
    read_chk(2'd2, 8'h00, "R1 requests");
    read_chk(2'd3, 8'h00, "R1 acks");

    for (int i = 0; i < NV; i++) begin
      cpu_wr = VEC[i].wr; cpu_addr = VEC[i].addr; cpu_wdata = VEC[i].wdata;
      sent_ok = VEC[i].sent; abort_done = VEC[i].abt; listen = VEC[i].lsn;
      init_req = VEC[i].init; init_ack = VEC[i].init;
      @(negedge clk);
      idle();
      check($sformatf("R%0d row %0d flags", VEC[i].req, i), {5'b0, ~buf_lock}, {5'b0, VEC[i].eflag});
      check($sformatf("R%0d row %0d irq", VEC[i].req, i), {7'b0, irq}, {7'b0, VEC[i].eirq});
    end
    listen = 1'b0; init_req = 1'b0; init_ack = 1'b0;

    // R12 enable write, read back with upper bits zero
    write(2'd1, 3'b001);
    check("R12 irq after enable", {7'b0, irq}, 8'h01);
    read_chk(2'd1, 8'h01, "R12 enable readback");
    // R7 request alone does not enter init mode
    init_req = 1'b1;
    write(2'd0, 3'b001);
    init_req = 1'b0;
    check("R7 one-sided init", {5'b0, buf_lock}, 8'h01);
    check("R9 irq drops", {7'b0, irq}, 8'h00);
    // R11 same-cycle clear and sent
    cpu_wr = 1'b1; cpu_addr = 2'd0; cpu_wdata = 3'b010; sent_ok = 3'b010;
    @(negedge clk);
    idle();
    check("R11 set beats clear", {5'b0, buf_lock}, 8'h01);
    // R5 R4 R6 abort handshake on buffer 0
    write(2'd2, 3'b001);
    read_chk(2'd2, 8'h01, "R5 request set");
    abort_done = 3'b001;
    @(negedge clk);
    idle();
    check("R4 abort frees buffer", {5'b0, buf_lock}, 8'h00);
    read_chk(2'd3, 8'h01, "R4 ack set");
    read_chk(2'd2, 8'h00, "R5 request cleared");
    read_chk(2'd0, 8'h07, "R2 flags upper zero");
    write(2'd0, 3'b001);
    read_chk(2'd3, 8'h00, "R6 ack cleared");
    // R5 request on empty buffer refused
    write(2'd2, 3'b100);
    read_chk(2'd2, 8'h00, "R5 request on empty");
    // R5 sent clears request without ack (R3)
    write(2'd2, 3'b001);
    read_chk(2'd2, 8'h01, "R5 request again");
    sent_ok = 3'b001;
    @(negedge clk);
    idle();
    read_chk(2'd2, 8'h00, "R5 sent drops request");
    read_chk(2'd3, 8'h00, "R3 sent gives no ack");
    check("R10 lock free", {5'b0, buf_lock}, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule